// File: doc/BRIEF.md
# Two-Phase Randomized Mesh Route Unit

This unit computes the next hop of a packet inside one node of a 2D mesh. It balances load obliviously: a packet that enters the network is first steered to a pseudo-randomly chosen waypoint node and is then steered from there to its real destination. Each of the two legs moves along X until the column matches, and only then along Y. The waypoint is chosen once, at injection, and is written into the packet header. The unit also keeps a leg flag in the header and sets it when the packet reaches the waypoint.

Two inputs shape the waypoint choice. A load flag turns the detour on. While the flag is low, an injected packet takes the plain X-then-Y path to its destination. A containment flag limits the waypoint to the mesh quadrant that holds the source. Apart from these two flags, the route never depends on the state of the network.

Each result is registered, so it appears one cycle after the header is presented. Link arbitration and buffering sit outside this unit.

Top module: `rand_route_unit`

## Requirements
- R1: While rst_ni is low, valid_o is 0, port_o is 0 (Local), and every header output is 0.
- R2: The waypoint generator is a 16-bit register that starts at 16'hACE1 on reset. On each cycle where valid_i and inject_i are both 1, it shifts left by one bit, and the new bit 0 is the XOR of state bits 15, 13, 12 and 10. No other cycle changes it.
- R3: On an injection with high_load_i=1 and quad_mode_i=0, the waypoint X is (state[7:0] mod MESH_W) and the waypoint Y is (state[15:8] mod MESH_H). Both use the generator state as it stood before that injection's shift. The leg flag starts at 0.
- R4: When quad_mode_i=1, each axis is handled on its own. The lower half of an axis runs from 0 to N/2-1 and the upper half from N/2 to N-1. If the source coordinate lies in the lower half, the waypoint coordinate is r mod (N/2). If it lies in the upper half, the waypoint coordinate is N/2 + r mod (N - N/2).
- R5: On an injection with high_load_i=0, the waypoint fields are set equal to the destination and the leg flag is output as 1.
- R6: If the chosen waypoint equals the current (source) coordinates, the leg flag is output as 1 in that same result.
- R7: On a transit hop (inject_i=0), a leg flag of 0 becomes 1 when the current coordinates equal the waypoint. A leg flag of 1 is never cleared.
- R8: The target is the waypoint while the leg flag is 0 and the destination while it is 1. Port codes are 1 East (x+1), 2 West (x-1), 3 North (y+1) and 4 South (y-1). East or West is chosen while X differs from the target, and North or South only once X matches.
- R9: Port 0 (Local) is output only when the leg flag is 1 and the current coordinates equal the destination. A packet that follows the port outputs ends at its destination.
- R10: valid_o is valid_i delayed by one cycle. When valid_i is 0, port_o and the header outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Header presented this cycle |
| inject_i | input | 1 | Packet is new at this node; choose its waypoint |
| high_load_i | input | 1 | Enable the random detour for injections |
| quad_mode_i | input | 1 | Keep the waypoint inside the source quadrant |
| cur_x_i | input | XW | Column of this node |
| cur_y_i | input | YW | Row of this node |
| dst_x_i | input | XW | Destination column |
| dst_y_i | input | YW | Destination row |
| mid_x_i | input | XW | Waypoint column from header (transit only) |
| mid_y_i | input | YW | Waypoint row from header (transit only) |
| phase_i | input | 1 | Leg flag from header (transit only) |
| valid_o | output | 1 | Result valid |
| port_o | output | 3 | Output port code |
| dst_x_o | output | XW | Destination column out |
| dst_y_o | output | YW | Destination row out |
| mid_x_o | output | XW | Waypoint column out |
| mid_y_o | output | YW | Waypoint row out |
| phase_o | output | 1 | Updated leg flag |

## Verification
The hardest case to reach is a waypoint that lands on the source node (R6). The generator is hidden inside the unit, so this case cannot be produced by sending random injections and waiting. The bench keeps its own copy of the generator sequence from reset and uses it to predict the next waypoint. It then injects a packet from exactly that node. Multi-hop walks close the loop: each hop's port and header are fed back as the next hop's input, which checks that both legs end at the destination.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/route_lfsr.sv
module route_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = 16'hB400,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign state_o = state_q;
endmodule

// File: rtl/mid_axis.sv
// Maps random bits onto one axis, optionally confined to the source half.
module mid_axis #(
  parameter int N  = 4,
  parameter int RW = 8,
  parameter int CW = 2
) (
  input  logic [RW-1:0] rnd_i,
  input  logic [CW-1:0] src_i,
  input  logic          quad_i,
  output logic [CW-1:0] mid_o
);
  localparam int NL = N / 2;
  localparam int NH = N - NL;

  logic [RW-1:0] m_full, m_lo, m_hi;
  logic          src_hi;

  generate
    if (N < 2) begin : g_single
      assign m_full = '0;
      assign m_lo   = '0;
      assign m_hi   = '0;
      assign src_hi = 1'b0;
    end else begin : g_split
      assign m_full = rnd_i % RW'(N);
      assign m_lo   = rnd_i % RW'(NL);
      assign m_hi   = rnd_i % RW'(NH);
      assign src_hi = src_i >= CW'(NL);
    end
  endgenerate

  always_comb begin
    if (!quad_i)     mid_o = CW'(m_full);
    else if (src_hi) mid_o = CW'(m_hi) + CW'(NL);
    else             mid_o = CW'(m_lo);
  end
endmodule

// File: rtl/xy_step.sv
module xy_step import route_pkg::*; #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] tgt_x_i,
  input  logic [YW-1:0] tgt_y_i,
  output port_e         port_o
);
  always_comb begin
    if      (cur_x_i < tgt_x_i) port_o = PORT_EAST;
    else if (cur_x_i > tgt_x_i) port_o = PORT_WEST;
    else if (cur_y_i < tgt_y_i) port_o = PORT_NORTH;
    else if (cur_y_i > tgt_y_i) port_o = PORT_SOUTH;
    else                        port_o = PORT_LOCAL;
  end
endmodule

// File: rtl/rand_route_unit.sv
module rand_route_unit import route_pkg::*; #(
  parameter int                MESH_W    = 4,
  parameter int                MESH_H    = 4,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int               XW        = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int               YW        = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          inject_i,
  input  logic          high_load_i,
  input  logic          quad_mode_i,
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [XW-1:0] mid_x_i,
  input  logic [YW-1:0] mid_y_i,
  input  logic          phase_i,
  output logic          valid_o,
  output logic [2:0]    port_o,
  output logic [XW-1:0] dst_x_o,
  output logic [YW-1:0] dst_y_o,
  output logic [XW-1:0] mid_x_o,
  output logic [YW-1:0] mid_y_o,
  output logic          phase_o
);
  localparam int RW = LFSR_W / 2;

  logic [LFSR_W-1:0] rnd;
  logic              gen_step;
  logic [XW-1:0]     pick_x, sel_x, tgt_x;
  logic [YW-1:0]     pick_y, sel_y, tgt_y;
  logic              ph_in, ph_nxt;
  port_e             port_nxt;

  assign gen_step = valid_i & inject_i;

  route_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (gen_step),
    .state_o (rnd)
  );

  mid_axis #(.N(MESH_W), .RW(RW), .CW(XW)) u_mid_x (
    .rnd_i  (rnd[RW-1:0]),
    .src_i  (cur_x_i),
    .quad_i (quad_mode_i),
    .mid_o  (pick_x)
  );

  mid_axis #(.N(MESH_H), .RW(RW), .CW(YW)) u_mid_y (
    .rnd_i  (rnd[2*RW-1:RW]),
    .src_i  (cur_y_i),
    .quad_i (quad_mode_i),
    .mid_o  (pick_y)
  );

  // Waypoint and leg selection; arrival at waypoint promotes to second leg.
  always_comb begin
    if (inject_i) begin
      sel_x = high_load_i ? pick_x : dst_x_i;
      sel_y = high_load_i ? pick_y : dst_y_i;
      ph_in = ~high_load_i;
    end else begin
      sel_x = mid_x_i;
      sel_y = mid_y_i;
      ph_in = phase_i;
    end
    ph_nxt = ph_in | ((sel_x == cur_x_i) & (sel_y == cur_y_i));
    tgt_x  = ph_nxt ? dst_x_i : sel_x;
    tgt_y  = ph_nxt ? dst_y_i : sel_y;
  end

  xy_step #(.XW(XW), .YW(YW)) u_xy (
    .cur_x_i (cur_x_i),
    .cur_y_i (cur_y_i),
    .tgt_x_i (tgt_x),
    .tgt_y_i (tgt_y),
    .port_o  (port_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      port_o  <= PORT_LOCAL;
      dst_x_o <= '0;
      dst_y_o <= '0;
      mid_x_o <= '0;
      mid_y_o <= '0;
      phase_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        port_o  <= port_nxt;
        dst_x_o <= dst_x_i;
        dst_y_o <= dst_y_i;
        mid_x_o <= sel_x;
        mid_y_o <= sel_y;
        phase_o <= ph_nxt;
      end
    end
  end
endmodule

// File: rtl/route_unit_chk.sv
module route_unit_chk #(
  parameter int MESH_W = 4,
  parameter int MESH_H = 4,
  localparam int XW = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int YW = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          inject_i,
  input logic          high_load_i,
  input logic          quad_mode_i,
  input logic [XW-1:0] cur_x_i,
  input logic [YW-1:0] cur_y_i,
  input logic          phase_i,
  input logic          valid_o,
  input logic [2:0]    port_o,
  input logic [XW-1:0] dst_x_o,
  input logic [YW-1:0] dst_y_o,
  input logic [XW-1:0] mid_x_o,
  input logic [YW-1:0] mid_y_o,
  input logic          phase_o
);
  localparam logic [2:0] LOC = 3'd0;
  localparam logic [2:0] NTH = 3'd3;
  localparam logic [2:0] STH = 3'd4;
  localparam int XL = MESH_W / 2;

  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, mid_x_o} < (XW+1)'(MESH_W)) && ({1'b0, mid_y_o} < (YW+1)'(MESH_H)));

  p_quad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && inject_i && high_load_i && quad_mode_i)
      |-> ((mid_x_o >= XW'(XL)) == ($past(cur_x_i) >= XW'(XL))));

  p_direct_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && inject_i && !high_load_i)
      |-> phase_o && mid_x_o == dst_x_o && mid_y_o == dst_y_o);

  p_self_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i && inject_i) && mid_x_o == $past(cur_x_i) && mid_y_o == $past(cur_y_i))
      |-> phase_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !inject_i && phase_i) |-> phase_o);

  p_x_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (port_o == NTH || port_o == STH))
      |-> $past(cur_x_i) == (phase_o ? dst_x_o : mid_x_o));

  p_local_dst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && port_o == LOC)
      |-> phase_o && $past(cur_x_i) == dst_x_o && $past(cur_y_i) == dst_y_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !valid_o && $stable(port_o) && $stable(mid_x_o) && $stable(phase_o));
endmodule

bind rand_route_unit route_unit_chk #(.MESH_W(MESH_W), .MESH_H(MESH_H)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .inject_i    (inject_i),
  .high_load_i (high_load_i),
  .quad_mode_i (quad_mode_i),
  .cur_x_i     (cur_x_i),
  .cur_y_i     (cur_y_i),
  .phase_i     (phase_i),
  .valid_o     (valid_o),
  .port_o      (port_o),
  .dst_x_o     (dst_x_o),
  .dst_y_o     (dst_y_o),
  .mid_x_o     (mid_x_o),
  .mid_y_o     (mid_y_o),
  .phase_o     (phase_o)
);

// File: tb/tb_rand_route_unit.sv
module tb_rand_route_unit;
  localparam int CLK_P = 10;
  localparam int W  = 4;
  localparam int H  = 4;
  localparam int XW = 2;
  localparam int YW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 0, inject_i = 0, high_load_i = 0, quad_mode_i = 0, phase_i = 0;
  logic [XW-1:0] cur_x_i = '0, dst_x_i = '0, mid_x_i = '0;
  logic [YW-1:0] cur_y_i = '0, dst_y_i = '0, mid_y_i = '0;
  logic valid_o, phase_o;
  logic [2:0] port_o;
  logic [XW-1:0] dst_x_o, mid_x_o;
  logic [YW-1:0] dst_y_o, mid_y_o;

  rand_route_unit #(.MESH_W(W), .MESH_H(H)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .inject_i(inject_i),
    .high_load_i(high_load_i), .quad_mode_i(quad_mode_i),
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .mid_x_i(mid_x_i), .mid_y_i(mid_y_i), .phase_i(phase_i),
    .valid_o(valid_o), .port_o(port_o), .dst_x_o(dst_x_o), .dst_y_o(dst_y_o),
    .mid_x_o(mid_x_o), .mid_y_o(mid_y_o), .phase_o(phase_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  int e_valid = 0, e_port = 0, e_dx = 0, e_dy = 0, e_mx = 0, e_my = 0, e_ph = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input int r, input int src, input int n, input bit q);
    int lo;
    lo = n / 2;
    if (!q) return r % n;
    if (src >= lo) return lo + r % (n - lo);
    return r % lo;
  endfunction

  // One presented header; reference model evaluated, then outputs compared.
  task automatic step(input bit v, input bit inj, input bit hl, input bit qd,
                      input int cx, input int cy, input int dx, input int dy,
                      input int mx, input int my, input int ph, input string tag);
    int tmx, tmy, tph, tx, ty;
    @(negedge clk);
    valid_i = v; inject_i = inj; high_load_i = hl; quad_mode_i = qd;
    cur_x_i = XW'(cx); cur_y_i = YW'(cy); dst_x_i = XW'(dx); dst_y_i = YW'(dy);
    mid_x_i = XW'(mx); mid_y_i = YW'(my); phase_i = ph[0];
    if (v) begin
      if (inj) begin
        if (hl) begin
          tmx = pick(int'(m_lfsr[7:0]), cx, W, qd);
          tmy = pick(int'(m_lfsr[15:8]), cy, H, qd);
          tph = 0;
        end else begin
          tmx = dx; tmy = dy; tph = 1;
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      end else begin
        tmx = mx; tmy = my; tph = ph;
      end
      if (tmx == cx && tmy == cy) tph = 1;
      tx = tph ? dx : tmx;
      ty = tph ? dy : tmy;
      if      (cx < tx) e_port = 1;
      else if (cx > tx) e_port = 2;
      else if (cy < ty) e_port = 3;
      else if (cy > ty) e_port = 4;
      else              e_port = 0;
      e_valid = 1; e_dx = dx; e_dy = dy; e_mx = tmx; e_my = tmy; e_ph = tph;
    end else begin
      e_valid = 0;
    end
    @(posedge clk);
    #(CLK_P/4);
    chk(tag, "valid", int'(valid_o), e_valid);
    chk(tag, "port",  int'(port_o),  e_port);
    chk(tag, "dst_x", int'(dst_x_o), e_dx);
    chk(tag, "dst_y", int'(dst_y_o), e_dy);
    chk(tag, "mid_x", int'(mid_x_o), e_mx);
    chk(tag, "mid_y", int'(mid_y_o), e_my);
    chk(tag, "phase", int'(phase_o), e_ph);
  endtask

  // Follow the port outputs hop by hop until Local (R7, R8, R9).
  task automatic walk(input int sx, input int sy, input int dx, input int dy, input bit qd);
    int cx, cy, p;
    cx = sx; cy = sy;
    step(1, 1, 1, qd, cx, cy, dx, dy, 0, 0, 0, "R8 walk inject");
    for (int i = 0; i < 24; i++) begin
      p = int'(port_o);
      if (p == 0) break;
      if (p == 1) cx++;
      else if (p == 2) cx--;
      else if (p == 3) cy++;
      else if (p == 4) cy--;
      step(1, 0, 1, qd, cx, cy, dx, dy, int'(mid_x_o), int'(mid_y_o), int'(phase_o), "R7 walk hop");
    end
    chk("R9 walk end", "port", int'(port_o), 0);
    chk("R9 walk end", "x", cx, dx);
    chk("R9 walk end", "y", cy, dy);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sx, sy;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1 reset", "valid", int'(valid_o), 0);
    chk("R1 reset", "port",  int'(port_o),  0);
    chk("R1 reset", "mid_x", int'(mid_x_o), 0);
    chk("R1 reset", "dst_y", int'(dst_y_o), 0);
    chk("R1 reset", "phase", int'(phase_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    step(1, 1, 0, 0, 1, 1, 3, 2, 0, 0, 0, "R5 direct east");
    step(1, 1, 0, 0, 2, 3, 2, 0, 0, 0, 0, "R5 R8 direct south");
    step(1, 1, 0, 0, 2, 2, 2, 2, 0, 0, 0, "R9 local at source");
    step(0, 0, 0, 0, 3, 3, 0, 0, 1, 1, 0, "R10 idle hold");
    step(0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R10 R2 idle inject ignored");

    step(1, 1, 1, 0, 0, 0, 3, 3, 0, 0, 0, "R2 R3 first pick from seed");
    for (int i = 0; i < 6; i++)
      step(1, 1, 1, 0, i % W, (i + 1) % H, (i + 2) % W, i % H, 0, 0, 0, "R3 pick sequence");
    step(1, 0, 1, 0, 0, 1, 3, 3, 2, 2, 0, "R2 transit no advance");
    step(1, 1, 1, 0, 1, 0, 2, 3, 0, 0, 0, "R2 after transit");

    step(1, 1, 1, 1, 0, 0, 3, 3, 0, 0, 0, "R4 quad low-low");
    step(1, 1, 1, 1, 3, 0, 0, 3, 0, 0, 0, "R4 quad high-low");
    step(1, 1, 1, 1, 1, 3, 3, 0, 0, 0, 0, "R4 quad low-high");
    step(1, 1, 1, 1, 2, 2, 0, 0, 0, 0, 0, "R4 quad high-high");

    sx = pick(int'(m_lfsr[7:0]), 0, W, 1'b0);
    sy = pick(int'(m_lfsr[15:8]), 0, H, 1'b0);
    step(1, 1, 1, 0, sx, sy, (sx + 2) % W, (sy + 1) % H, 0, 0, 0, "R6 waypoint equals source");

    step(1, 0, 1, 0, 1, 2, 3, 0, 1, 2, 0, "R7 arrive at waypoint");
    step(1, 0, 0, 0, 0, 3, 2, 2, 3, 0, 1, "R7 leg flag sticky");
    step(1, 0, 1, 0, 2, 1, 3, 3, 0, 3, 0, "R8 x before y to waypoint");
    step(1, 0, 1, 0, 0, 1, 3, 3, 0, 3, 0, "R8 north once x matches");
    step(1, 0, 1, 0, 2, 2, 2, 0, 1, 1, 1, "R8 south on second leg");

    walk(0, 0, 3, 3, 1'b0);
    walk(3, 1, 0, 2, 1'b1);
    walk(2, 3, 1, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule